// File: doc/BRIEF.md
# External Interrupt Pin Monitor

This block watches up to seven external interrupt pins, numbered 1 through 7, and turns their activity into one interrupt request per pin for a downstream interrupt controller. Position 0 of every per-pin vector is reserved and has no pin behind it. Each pin passes through a synchronizer. Its trigger mode then decides whether the request follows the pin level or comes from a latched event flag.

Software reaches the block through a small register bus: a two-bit register select, a write strobe, write data and combinational read data. Through this bus software sets each pin's direction bit, its trigger mode and its interrupt enable, and clears latched event flags by writing ones. The direction bits go straight out on a port for the pad logic.

Top module: `edge_irq_port`

## Requirements
- R1: After reset every register reads zero and no interrupt request is asserted.
- R2: Position 0 is reserved. Bit 0 of the direction, enable and flag registers and bits 1:0 of the trigger register always read zero, and `irqReq[0]` and `pinDir[0]` never assert.
- R3: Select 0 is the 16-bit trigger register. Pin p owns bits [2p+1:2p], coded 00 level (active low), 01 rising edge, 10 falling edge, 11 either edge.
- R4: For a pin in level mode, `irqReq[p]` is high exactly while its enable bit is set and its synchronized input is low. It follows a pin change two clock edges after the pin is sampled.
- R5: In rising mode a low-to-high transition on the synchronized pin sets the pin's flag, three clock edges after the pin is sampled. The flag stays set after the pin changes again, and a falling transition sets nothing.
- R6: In falling mode a high-to-low transition sets the flag, and a rising transition does not.
- R7: In either-edge mode both kinds of transition set the flag.
- R8: Select 3 is the flag register. Writing 1 to a bit clears that flag, writing 0 leaves it unchanged, and a flag never clears in any other way.
- R9: If an edge on a pin is detected in the same cycle as a clearing write to that pin's flag, the flag remains set.
- R10: Select 2 is the enable register. In edge modes `irqReq[p]` equals enable AND flag. A flag latches whether or not the pin is enabled.
- R11: Select 1 is the direction register. Its value (1 = output, 0 = input) drives `pinDir` from the cycle after the write.
- R12: A pin in level mode never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register select: 0 trigger, 1 direction, 2 enable, 3 flag |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 16 | Write data; 8-bit registers use bits 7:0 |
| rdData | output | 16 | Combinational read data of the selected register |
| pinIn | input | 8 | Raw external pin levels, bit p is pin p |
| pinDir | output | 8 | Direction bits to the pads, 1 = output |
| irqReq | output | 8 | Interrupt request per pin |

## Verification
The bound assertions check on every cycle that the reserved position stays quiet, that requests never appear on disabled pins, and that requests follow the level or the flag according to each pin's mode. They also check that flags clear only through a one-written clear, that a clear coinciding with an edge loses nothing, that level-mode pins never latch, and that direction writes reach the pads. Only the bench's scenarios show the synchronizer latency, the correct edge polarity for each of the four codes, and the field position of each pin in the trigger register. The bench does this with a behavioural reference model that is compared on every clock.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trigMode_t;

  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_FLAG = 2'd3
  } regSel_t;

  typedef struct packed {
    logic wrTrig;
    logic wrDir;
    logic wrEnable;
    logic clrFlag;
  } eirqStrobe_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] trigQ,
  input  logic [PIN_W-1:0]  dirQ,
  input  logic [PIN_W-1:0]  enQ,
  input  logic [PIN_W-1:0]  flagQ,
  output eirqStrobe_t       stb,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - PIN_W;

  regSel_t sel;
  assign sel = regSel_t'(regSel);

  always_comb begin
    stb          = '0;
    stb.wrTrig   = wrEn && (sel == SEL_TRIG);
    stb.wrDir    = wrEn && (sel == SEL_DIR);
    stb.wrEnable = wrEn && (sel == SEL_EN);
    stb.clrFlag  = wrEn && (sel == SEL_FLAG);
  end

  always_comb begin
    unique case (sel)
      SEL_TRIG: rdData = trigQ;
      SEL_DIR:  rdData = {{PAD_W{1'b0}}, dirQ};
      SEL_EN:   rdData = {{PAD_W{1'b0}}, enQ};
      SEL_FLAG: rdData = {{PAD_W{1'b0}}, flagQ};
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/eirq_datapath.sv
module eirq_datapath
  import eirq_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int SYNC_STAGES = 2,
  parameter int PIN_W       = NUM_PINS + 1,
  parameter int DATA_W      = 2 * PIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eirqStrobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [DATA_W-1:0] trigQ,
  output logic [PIN_W-1:0]  dirQ,
  output logic [PIN_W-1:0]  enQ,
  output logic [PIN_W-1:0]  flagQ,
  output logic [PIN_W-1:0]  syncQ,
  output logic [PIN_W-1:0]  edgeHit,
  output logic [PIN_W-1:0]  irqReq
);

  localparam logic [PIN_W-1:0]  PIN_MASK  = {{NUM_PINS{1'b1}}, 1'b0};
  localparam logic [DATA_W-1:0] TRIG_MASK = {{(DATA_W-2){1'b1}}, 2'b00};

  logic [PIN_W-1:0] syncPrev;
  logic [PIN_W-1:0] clrMask;
  logic [PIN_W-1:0] wrByte;

  assign wrByte  = wrData[PIN_W-1:0];
  assign clrMask = stb.clrFlag ? wrByte : '0;

  eirq_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_W)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinIn),
    .dOut (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= '0;
    else       syncPrev <= syncQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ <= '0;
      dirQ  <= '0;
      enQ   <= '0;
    end else begin
      if (stb.wrTrig)   trigQ <= wrData & TRIG_MASK;
      if (stb.wrDir)    dirQ  <= wrByte & PIN_MASK;
      if (stb.wrEnable) enQ   <= wrByte & PIN_MASK;
    end
  end

  // A new edge wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= ((flagQ & ~clrMask) | edgeHit) & PIN_MASK;
  end

  assign edgeHit[0] = 1'b0;
  assign irqReq[0]  = 1'b0;

  generate
    for (genvar p = 1; p < PIN_W; p++) begin : g_pin
      trigMode_t mode;
      logic      rise;
      logic      fall;

      assign mode = trigMode_t'(trigQ[2*p +: 2]);
      assign rise = syncQ[p] & ~syncPrev[p];
      assign fall = ~syncQ[p] & syncPrev[p];

      always_comb begin
        unique case (mode)
          TRIG_LEVEL: edgeHit[p] = 1'b0;
          TRIG_RISE:  edgeHit[p] = rise;
          TRIG_FALL:  edgeHit[p] = fall;
          TRIG_BOTH:  edgeHit[p] = rise | fall;
          default:    edgeHit[p] = 1'b0;
        endcase
      end

      assign irqReq[p] = enQ[p] & ((mode == TRIG_LEVEL) ? ~syncQ[p] : flagQ[p]);
    end
  endgenerate

endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
  import eirq_pkg::*;
#(
  parameter  int NUM_PINS    = 7,
  parameter  int SYNC_STAGES = 2,
  localparam int PIN_W       = NUM_PINS + 1,
  localparam int DATA_W      = 2 * PIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinDir,
  output logic [PIN_W-1:0]  irqReq
);

  eirqStrobe_t       stb;
  logic [DATA_W-1:0] trigQ;
  logic [PIN_W-1:0]  dirQ;
  logic [PIN_W-1:0]  enQ;
  logic [PIN_W-1:0]  flagQ;
  logic [PIN_W-1:0]  syncQ;
  logic [PIN_W-1:0]  edgeHit;

  eirq_ctrl #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_ctrl (
    .wrEn   (wrEn),
    .regSel (regSel),
    .trigQ  (trigQ),
    .dirQ   (dirQ),
    .enQ    (enQ),
    .flagQ  (flagQ),
    .stb    (stb),
    .rdData (rdData)
  );

  eirq_datapath #(
    .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES), .PIN_W(PIN_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .trigQ   (trigQ),
    .dirQ    (dirQ),
    .enQ     (enQ),
    .flagQ   (flagQ),
    .syncQ   (syncQ),
    .edgeHit (edgeHit),
    .irqReq  (irqReq)
  );

  assign pinDir = dirQ;

endmodule

// File: rtl/edge_irq_port_chk.sv
module edge_irq_port_chk #(
  parameter int PIN_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        regSel,
  input logic [DATA_W-1:0] wrData,
  input logic [PIN_W-1:0]  irqReq,
  input logic [PIN_W-1:0]  pinDir,
  input logic [PIN_W-1:0]  enQ,
  input logic [PIN_W-1:0]  flagQ,
  input logic [DATA_W-1:0] trigQ,
  input logic [PIN_W-1:0]  syncQ,
  input logic [PIN_W-1:0]  edgeHit
);

  localparam logic [PIN_W-1:0] PIN_MASK = {{(PIN_W-1){1'b1}}, 1'b0};

  logic [PIN_W-1:0] levelMask;
  logic             clrWrite;
  logic             dirWrite;

  always_comb begin
    levelMask = '0;
    for (int p = 1; p < PIN_W; p++) levelMask[p] = (trigQ[2*p +: 2] == 2'b00);
  end

  assign clrWrite = wrEn && (regSel == 2'd3);
  assign dirWrite = wrEn && (regSel == 2'd1);

  p_bit0_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq[0] && !pinDir[0] && !flagQ[0]);

  p_enable_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~enQ) == '0);

  p_level_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq ^ (enQ & ~syncQ)) & levelMask & PIN_MASK) == '0);

  p_edge_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq ^ (enQ & flagQ)) & ~levelMask & PIN_MASK) == '0);

  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite |=> (flagQ & $past(wrData[PIN_W-1:0]) & ~$past(edgeHit)) == '0);

  p_no_silent_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !clrWrite |=> (~flagQ & $past(flagQ)) == '0);

  p_edge_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHit != '0) |=> (flagQ & $past(edgeHit)) == $past(edgeHit));

  p_level_no_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (flagQ & ~$past(flagQ) & $past(levelMask)) == '0);

  p_dir_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    dirWrite |=> pinDir == ($past(wrData[PIN_W-1:0]) & PIN_MASK));

endmodule

bind edge_irq_port edge_irq_port_chk #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .regSel  (regSel),
  .wrData  (wrData),
  .irqReq  (irqReq),
  .pinDir  (pinDir),
  .enQ     (enQ),
  .flagQ   (flagQ),
  .trigQ   (trigQ),
  .syncQ   (syncQ),
  .edgeHit (edgeHit)
);

// File: tb/edge_irq_port_tb.sv
`timescale 1ns/1ps
module edge_irq_port_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic [7:0]  pinIn = 8'hFF;
  logic [7:0]  pinDir;
  logic [7:0]  irqReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_irq_port u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinDir(pinDir), .irqReq(irqReq)
  );

  // Behavioural reference state
  bit [7:0]  mS1, mS2, mPrev, mFlag, mDir, mEn;
  bit [15:0] mTrig;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mFlag = 0; mDir = 0; mEn = 0; mTrig = 0;
    end else begin : upd
      bit [7:0] hit;
      int m;
      bit up, dn;
      hit = 0;
      for (int p = 1; p < 8; p++) begin
        m  = int'((mTrig >> (2 * p)) & 16'h3);
        up = mS2[p] && !mPrev[p];
        dn = !mS2[p] && mPrev[p];
        if ((m == 1 && up) || (m == 2 && dn) || (m == 3 && (up || dn))) hit[p] = 1'b1;
      end
      if (wrEn && regSel == 2'd3) mFlag = mFlag & ~wrData[7:0];
      mFlag = (mFlag | hit) & 8'hFE;
      if (wrEn) begin
        case (regSel)
          2'd0: mTrig = wrData & 16'hFFFC;
          2'd1: mDir  = wrData[7:0] & 8'hFE;
          2'd2: mEn   = wrData[7:0] & 8'hFE;
          default: ;
        endcase
      end
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  function automatic bit [7:0] expIrq();
    bit [7:0] r;
    int m;
    r = 0;
    for (int p = 1; p < 8; p++) begin
      m = int'((mTrig >> (2 * p)) & 16'h3);
      if (m == 0) r[p] = mEn[p] & !mS2[p];
      else        r[p] = mEn[p] & mFlag[p];
    end
    return r;
  endfunction

  function automatic bit [15:0] expRd(input bit [1:0] a);
    case (a)
      2'd0: return mTrig;
      2'd1: return {8'h0, mDir};
      2'd2: return {8'h0, mEn};
      default: return {8'h0, mFlag};
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("cycle irqReq (R4 R5 R6 R7 R10)", {8'h0, irqReq}, {8'h0, expIrq()});
      check("cycle pinDir (R11)", {8'h0, pinDir}, {8'h0, mDir});
      check("cycle rdData (R3 R8 R9 R12)", rdData, expRd(regSel));
    end
  end

  task automatic wr(input bit [1:0] a, input bit [15:0] d);
    @(negedge clk); #2;
    regSel = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic rd(input bit [1:0] a, output logic [15:0] v);
    @(negedge clk); #2;
    regSel = a; #1;
    v = rdData;
  endtask

  task automatic setPin(input int p, input bit v);
    @(negedge clk); #2;
    pinIn[p] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] v;
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    idle(2);

    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 register reset value", v, 16'h0);
    end
    check("R1 irqReq after reset", {8'h0, irqReq}, 16'h0);

    wr(2'd1, 16'h00FF);
    rd(2'd1, v);
    check("R2 direction bit 0 reserved", v, 16'h00FE);
    check("R11 pinDir follows direction", {8'h0, pinDir}, 16'h00FE);
    wr(2'd1, 16'h0006);
    check("R11 pinDir rewritten", {8'h0, pinDir}, 16'h0006);

    wr(2'd2, 16'h00FF);
    rd(2'd2, v);
    check("R2 enable bit 0 reserved", v, 16'h00FE);

    check("R4 level idle high", {8'h0, irqReq}, 16'h0);
    setPin(3, 1'b0); idle(3);
    check("R4 level low asserts", {8'h0, irqReq}, 16'h0008);
    setPin(3, 1'b1); idle(3);
    check("R4 level high releases", {8'h0, irqReq}, 16'h0);
    rd(2'd3, v);
    check("R12 level mode latches no flag", v, 16'h0);

    wr(2'd0, 16'hC813);
    rd(2'd0, v);
    check("R3 trigger fields, R2 bits 1:0", v, 16'hC810);

    setPin(2, 1'b0); idle(4);
    rd(2'd3, v);
    check("R5 falling ignored in rising mode", v, 16'h0);
    setPin(2, 1'b1); idle(4);
    rd(2'd3, v);
    check("R5 rising sets flag", v, 16'h0004);
    check("R5 rising request", {8'h0, irqReq}, 16'h0004);

    wr(2'd3, 16'h0000);
    rd(2'd3, v);
    check("R8 zero write keeps flag", v, 16'h0004);
    wr(2'd3, 16'h0004);
    rd(2'd3, v);
    check("R8 one write clears flag", v, 16'h0);
    check("R8 request drops after clear", {8'h0, irqReq}, 16'h0);

    setPin(5, 1'b0); idle(4);
    rd(2'd3, v);
    check("R6 falling sets flag", v, 16'h0020);
    setPin(5, 1'b1); idle(4);
    rd(2'd3, v);
    check("R6 rising does not clear or add", v, 16'h0020);

    wr(2'd2, 16'h00DE);
    check("R10 disabled pin has no request", {8'h0, irqReq}, 16'h0);

    setPin(7, 1'b0); idle(4);
    rd(2'd3, v);
    check("R7 both-edge falling", v, 16'h00A0);
    wr(2'd3, 16'h0080);
    setPin(7, 1'b1); idle(4);
    rd(2'd3, v);
    check("R7 both-edge rising", v, 16'h00A0);

    setPin(7, 1'b0); idle(1);
    wr(2'd3, 16'h0080);
    idle(2);
    rd(2'd3, v);
    check("R9 edge beats same-cycle clear", v, 16'h00A0);

    setPin(5, 1'b0); idle(4);
    rd(2'd3, v);
    check("R10 flag latches while disabled", v, 16'h00A0);

    setPin(4, 1'b0); idle(3);
    check("R4 level plus edge requests", {8'h0, irqReq}, 16'h0090);
    rd(2'd3, v);
    check("R12 level pin low sets no flag", v, 16'h00A0);

    setPin(0, 1'b0); idle(4);
    check("R2 pin 0 ignored", {8'h0, irqReq}, 16'h0090);

    idle(2);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule